// File: doc/BRIEF.md
# Modulated Tone Output Generator

The block drives one output pin with either a tone pattern or a timer square wave. The tone pattern is built from an 8-bit control word. A free-running 15-bit binary divider advances once per pulse of a 32.768 kHz reference enable. Each divider bit toggles at a fixed power-of-two fraction of that rate. The upper two bits of the control word pick the carrier: a steady low or high level, or an audio square wave at 2048 Hz or 4096 Hz. The lower six bits switch in slow modulator square waves. The enabled modulators are ORed into one envelope, and the envelope either gates the audio carrier or replaces a steady level.

Software writes the word with a one-cycle strobe. The word is held in a shadow register and copied to the active register on the next reference pulse, so a change always starts on the divider's own time grid. The divider is never cleared by a write. A separate mode input routes an externally generated timer toggle signal to the pin in place of the tone pattern. The pin is driven from a register and is low out of reset.

Top module: `mfp_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `mfp_out` is 0.
- R2: With control bits 5:0 all zero, the pattern is set by bits 7:6: 00 gives 0, 01 gives 1, 10 gives divider bit 3 (2048 Hz), and 11 gives divider bit 2 (4096 Hz).
- R3: Control bits 0,1,2,3,4,5 enable modulators equal to divider bits 7,8,11,12,13,14 (128, 64, 8, 4, 2 and 1 Hz).
- R4: With an audio carrier (bits 7:6 = 10 or 11) and at least one modulator enabled, the pattern is the carrier ANDed with the modulator envelope.
- R5: With a steady carrier code (bits 7:6 = 00 or 01) and at least one modulator enabled, the pattern is the modulator envelope alone.
- R6: When several modulator bits are set, the envelope is the OR of the enabled modulator signals.
- R7: When `timer_sel` is 1, `mfp_out` follows `timer_wave`; when it is 0, `mfp_out` follows the tone pattern.
- R8: A control word written in one cycle becomes active on the first `ref_tick` pulse in a later cycle; until then the output pattern does not change.
- R9: The divider starts at 0 after reset and advances by one on every `ref_tick` pulse, whether or not a control write occurs.
- R10: `mfp_out` is registered: it shows the selected source one clock cycle after that source's inputs settle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word: bits 7:6 carrier code, bits 5:0 modulator enables |
| timer_sel | input | 1 | 1 selects the timer signal, 0 the tone pattern |
| timer_wave | input | 1 | Timer toggle signal from outside |
| mfp_out | output | 1 | Output pin |

## Verification
A divider that skips or repeats a reference pulse shifts the phase of every tap. A comparison against an independent reference count therefore shows a mismatch at the next edge of the 4096 Hz tap, which is within four reference pulses. A corrupted active word shows up as a wrong level or a wrong frequency on the pin one clock after the next reference pulse. A write that leaks past the shadow register changes the pin before any pulse arrives, so idle cycles right after a write expose it. A cleared divider shows up as a phase jump on the carriers at the moment of the write.

// File: rtl/mfp_pkg.sv
`timescale 1ns/1ps
package mfp_pkg;
   localparam int unsigned MOD_N  = 6;
   localparam int unsigned CTRL_W = 8;

   typedef enum logic [1:0] {
      CAR_LOW  = 2'b00,
      CAR_HIGH = 2'b01,
      CAR_SLOW = 2'b10,
      CAR_FAST = 2'b11
   } carrier_e;

   typedef struct packed {
      carrier_e         car;
      logic [MOD_N-1:0] mods;
   } mfp_ctrl_t;
endpackage

// File: rtl/mfp_divider.sv
`timescale 1ns/1ps
module mfp_divider #(
   parameter int unsigned CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   output logic [CNT_W-1:0] cnt
);
   if (CNT_W < 2) begin : g_bad_width
      $error("mfp_divider: CNT_W too small");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (ref_tick) begin
         cnt <= cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/mfp_ctrl_reg.sv
`timescale 1ns/1ps
module mfp_ctrl_reg
   import mfp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   output mfp_ctrl_t         active
);
   mfp_ctrl_t shadow_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_q <= '0;
      end else if (wr_en) begin
         shadow_q <= mfp_ctrl_t'(wr_data);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= '0;
      end else if (ref_tick) begin
         active <= shadow_q;
      end
   end
endmodule

// File: rtl/mfp_wave_mux.sv
`timescale 1ns/1ps
module mfp_wave_mux
   import mfp_pkg::*;
#(
   parameter int unsigned CNT_W          = 15,
   parameter int unsigned TAP_FAST       = 2,
   parameter int unsigned TAP_SLOW       = 3,
   parameter int unsigned MOD_TAP [MOD_N] = '{7, 8, 11, 12, 13, 14}
) (
   input  logic [CNT_W-1:0] cnt,
   input  mfp_ctrl_t        cfg,
   output logic             wave
);
   if (TAP_FAST >= CNT_W || TAP_SLOW >= CNT_W) begin : g_bad_carrier
      $error("mfp_wave_mux: carrier tap beyond divider");
   end

   logic [MOD_N-1:0] gated;
   logic             carrier;
   logic             envelope;
   logic             any_mod;

   for (genvar i = 0; i < MOD_N; i++) begin : g_mod
      if (MOD_TAP[i] >= CNT_W) begin : g_bad_tap
         $error("mfp_wave_mux: modulator tap beyond divider");
      end
      assign gated[i] = cfg.mods[i] & cnt[MOD_TAP[i]];
   end

   assign envelope = |gated;
   assign any_mod  = |cfg.mods;

   always_comb begin
      unique case (cfg.car)
         CAR_LOW:  carrier = 1'b0;
         CAR_HIGH: carrier = 1'b1;
         CAR_SLOW: carrier = cnt[TAP_SLOW];
         CAR_FAST: carrier = cnt[TAP_FAST];
         default:  carrier = 1'b0;
      endcase
   end

   always_comb begin
      if (!any_mod) begin
         wave = carrier;
      end else if (cfg.car[1]) begin
         wave = carrier & envelope;
      end else begin
         wave = envelope;
      end
   end
endmodule

// File: rtl/mfp_gen.sv
`timescale 1ns/1ps
module mfp_gen
   import mfp_pkg::*;
#(
   parameter int unsigned CNT_W          = 15,
   parameter int unsigned TAP_FAST       = 2,
   parameter int unsigned TAP_SLOW       = 3,
   parameter int unsigned MOD_TAP [MOD_N] = '{7, 8, 11, 12, 13, 14}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   input  logic              timer_sel,
   input  logic              timer_wave,
   output logic              mfp_out
);
   logic [CNT_W-1:0] cnt_q;
   mfp_ctrl_t        act_q;
   logic             tone;

   mfp_divider #(.CNT_W(CNT_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_tick (ref_tick),
      .cnt      (cnt_q)
   );

   mfp_ctrl_reg u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_tick (ref_tick),
      .wr_en    (ctrl_we),
      .wr_data  (ctrl_wdata),
      .active   (act_q)
   );

   mfp_wave_mux #(
      .CNT_W    (CNT_W),
      .TAP_FAST (TAP_FAST),
      .TAP_SLOW (TAP_SLOW),
      .MOD_TAP  (MOD_TAP)
   ) u_mux (
      .cnt  (cnt_q),
      .cfg  (act_q),
      .wave (tone)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mfp_out <= 1'b0;
      end else begin
         mfp_out <= timer_sel ? timer_wave : tone;
      end
   end
endmodule

// File: rtl/mfp_gen_chk.sv
`timescale 1ns/1ps
module mfp_gen_chk
   import mfp_pkg::*;
#(
   parameter int unsigned CNT_W    = 15,
   parameter int unsigned TAP_SLOW = 3,
   parameter int unsigned TAP_MOD0 = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ref_tick,
   input logic             timer_sel,
   input logic             timer_wave,
   input logic             mfp_out,
   input logic [CNT_W-1:0] cnt_q,
   input mfp_ctrl_t        act_q
);
   // R1
   reset_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !mfp_out);

   // R7
   timer_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timer_sel |=> mfp_out == $past(timer_wave));

   // R8
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_tick |=> $stable(act_q));

   // R9
   div_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_tick |=> cnt_q == $past(cnt_q) + CNT_W'(1));

   // R9
   div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_tick |=> $stable(cnt_q));

   // R2
   dc_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!timer_sel && act_q.mods == '0 && !act_q.car[1])
      |=> mfp_out == $past(act_q.car[0]));

   // R5
   dc_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!timer_sel && !act_q.car[1] && act_q.mods == MOD_N'(1))
      |=> mfp_out == $past(cnt_q[TAP_MOD0]));

   // R4
   gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!timer_sel && act_q.car == CAR_SLOW && act_q.mods != '0 && !cnt_q[TAP_SLOW])
      |=> !mfp_out);
endmodule

bind mfp_gen mfp_gen_chk #(
   .CNT_W    (CNT_W),
   .TAP_SLOW (TAP_SLOW),
   .TAP_MOD0 (MOD_TAP[0])
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ref_tick   (ref_tick),
   .timer_sel  (timer_sel),
   .timer_wave (timer_wave),
   .mfp_out    (mfp_out),
   .cnt_q      (cnt_q),
   .act_q      (act_q)
);

// File: tb/tb_mfp_gen.sv
`timescale 1ns/1ps
module tb_mfp_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_tick = 1'b0;
   logic       ctrl_we = 1'b0;
   logic [7:0] ctrl_wdata = 8'h00;
   logic       timer_sel = 1'b0;
   logic       timer_wave = 1'b0;
   logic       mfp_out;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mfp_gen dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_tick   (ref_tick),
      .ctrl_we    (ctrl_we),
      .ctrl_wdata (ctrl_wdata),
      .timer_sel  (timer_sel),
      .timer_wave (timer_wave),
      .mfp_out    (mfp_out)
   );

   // reference model written from the requirements
   logic [14:0] m_cnt;
   logic [7:0]  m_shadow, m_act;
   logic        m_exp;

   function automatic logic ref_wave(input logic [7:0] w, input logic [14:0] c);
      logic car, env;
      case (w[7:6])
         2'b00: car = 1'b0;
         2'b01: car = 1'b1;
         2'b10: car = c[3];
         default: car = c[2];
      endcase
      env = (w[0] & c[7]) | (w[1] & c[8]) | (w[2] & c[11]) |
            (w[3] & c[12]) | (w[4] & c[13]) | (w[5] & c[14]);
      if (w[5:0] == 6'd0) return car;
      if (w[7]) return car & env;
      return env;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt <= '0; m_shadow <= '0; m_act <= '0; m_exp <= 1'b0;
      end else begin
         if (ctrl_we) m_shadow <= ctrl_wdata;
         if (ref_tick) begin
            m_cnt <= m_cnt + 15'd1;
            m_act <= m_shadow;
         end
         m_exp <= timer_sel ? timer_wave : ref_wave(m_act, m_cnt);
      end
   end

   int tw_cnt = 0;
   bit tw_run = 1'b0;
   always @(negedge clk) begin
      tw_cnt <= tw_cnt + 1;
      if (tw_run) timer_wave <= tw_cnt[1] ^ tw_cnt[3];
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic write_word(input logic [7:0] w);
      @(negedge clk);
      ctrl_we = 1'b1; ctrl_wdata = w; ref_tick = 1'b0;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   // ticks every cycle, compares pin with model on every cycle
   task automatic run_cmp(input int n, input string tag);
      int bad = 0;
      int last_a = 0, last_e = 0;
      for (int i = 0; i < n; i++) begin
         ref_tick = 1'b1;
         @(negedge clk);
         if (mfp_out !== m_exp) begin
            bad++; last_a = int'(mfp_out); last_e = int'(m_exp);
         end
      end
      ref_tick = 1'b0;
      check(bad == 0, tag, last_a, last_e);
   endtask

   task automatic count_rises(input int n, output int rises);
      logic prev;
      rises = 0;
      ref_tick = 1'b1;
      @(negedge clk);
      prev = mfp_out;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (mfp_out && !prev) rises++;
         prev = mfp_out;
      end
      ref_tick = 1'b0;
   endtask

   localparam int NV = 11;
   localparam logic [8:0] VEC [NV] = '{
      {1'b0, 8'h00}, {1'b0, 8'h40}, {1'b0, 8'h80}, {1'b0, 8'hC0},
      {1'b0, 8'h81}, {1'b0, 8'hC2}, {1'b0, 8'h04}, {1'b0, 8'h48},
      {1'b0, 8'h83}, {1'b0, 8'h10}, {1'b1, 8'h80}
   };
   localparam string VTAG [NV] = '{
      "R2 low", "R2 high", "R2 2048Hz", "R2 4096Hz",
      "R4 R3 gate 128Hz", "R4 R3 gate 64Hz", "R5 R3 8Hz", "R5 R3 4Hz",
      "R6 OR envelope", "R5 R3 2Hz", "R7 timer"
   };

   initial begin
      int r;
      repeat (4) @(negedge clk);
      check(mfp_out === 1'b0, "R1 in reset", int'(mfp_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(mfp_out === 1'b0, "R1 after reset", int'(mfp_out), 0);

      // vector table, each entry compared against the model (R9 continuity)
      for (int v = 0; v < NV; v++) begin
         timer_sel = VEC[v][8];
         tw_run = VEC[v][8];
         write_word(VEC[v][7:0]);
         run_cmp(2048, VTAG[v]);
      end
      timer_sel = 1'b0; tw_run = 1'b0;

      // R7 R10: timer path registered one cycle
      timer_sel = 1'b1; timer_wave = 1'b1;
      @(negedge clk);
      check(mfp_out === 1'b1, "R7 R10 timer high", int'(mfp_out), 1);
      timer_wave = 1'b0;
      @(negedge clk);
      check(mfp_out === 1'b0, "R7 R10 timer low", int'(mfp_out), 0);
      timer_sel = 1'b0;

      // R8: write without tick leaves output alone
      write_word(8'h40);
      ref_tick = 1'b1; @(negedge clk); ref_tick = 1'b0;
      repeat (2) @(negedge clk);
      check(mfp_out === 1'b1, "R8 high active", int'(mfp_out), 1);
      write_word(8'h00);
      repeat (4) @(negedge clk);
      check(mfp_out === 1'b1, "R8 no tick no change", int'(mfp_out), 1);
      ref_tick = 1'b1; @(negedge clk); ref_tick = 1'b0;
      @(negedge clk);
      check(mfp_out === 1'b0, "R8 R10 after tick", int'(mfp_out), 0);

      // R2 frequencies by edge counting
      write_word(8'hC0);
      run_cmp(4, "R2 settle");
      count_rises(160, r);
      check(r == 20, "R2 4096Hz rises", r, 20);
      write_word(8'h80);
      run_cmp(4, "R2 settle");
      count_rises(160, r);
      check(r == 10, "R2 2048Hz rises", r, 10);

      // R9: rewrites mid-run must not disturb divider phase
      for (int k = 0; k < 4; k++) begin
         write_word(8'h80);
         run_cmp(37, "R9 rewrite keeps phase");
      end

      // R3 R5: slowest modulator, one full period
      write_word(8'h20);
      run_cmp(4, "R5 settle");
      count_rises(32768, r);
      check(r == 1, "R3 1Hz rises", r, 1);
      run_cmp(1000, "R5 1Hz model");

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(150000 * 5);
      if (!done) begin
         done = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule